// File: doc/BRIEF.md
# Cache Line Refill and Write-Back Bus Engine

This block moves a single cache line between a CPU-side cache controller and a slower memory over a narrow word-wide bus. The bus and memory advance only on a clock enable that is high one CPU clock in every `BUS_DIV`. The controller hands over one request: a line address, a word offset inside the line, a direction (refill or write-back) and a mode flag. The engine then runs a single address beat and waits a fixed number of bus cycles for the memory. After that it moves the line one word per bus beat.

A refill with the critical-word flag set fetches the requested word in the first data beat. The remaining words follow in wrap-around order. The first word raises a one-clock early-restart pulse so the CPU can resume while the rest of the line is still arriving. A refill without the flag runs words from offset 0 upward and releases the CPU only with the last word. In both cases the line is declared valid only once all words are in.

A write-back reads the dirty words from the cache by index, in order from 0. It drives them onto the bus and then waits out the memory store latency before it reports completion. Tag storage, replacement and the memory itself are outside the block.

Top module: `line_xfer_engine`

## Requirements
- R1: `bus_tick` is high for exactly one CPU clock in every `BUS_DIV` (4) clocks. `bus_addr_strobe` and `bus_beat_strobe` are high only in clocks where `bus_tick` is high.
- R2: `busy` rises in the clock after a request is accepted and stays high until the clock in which `done` pulses. In that clock `busy` is already low. A request is accepted when `req_valid` is high and `busy` is low.
- R3: Each accepted request produces exactly one address beat. It falls on the first bus tick after acceptance, within 1 to `BUS_DIV` clocks, and `bus_addr` carries the accepted line address.
- R4: On a refill, the first data beat comes `MEM_LAT + 1` (11) bus ticks after the address beat. One beat then follows on every tick, for exactly `LINE_WORDS` (8) beats.
- R5: On a refill with `req_crit_first` = 1 and offset `o`, beat `j` carries word `(o + j) mod 8` on `bus_beat_idx`. One clock after each beat, `fill_valid` pulses with `fill_idx` equal to that index and `fill_data` equal to the `bus_rdata` value sampled in that beat.
- R6: On a refill with `req_crit_first` = 0, beat `j` carries word `j`, whatever the offset.
- R7: `cpu_restart` pulses exactly once per refill. With critical-word-first it pulses together with the first `fill_valid`. Without it, it pulses together with the last `fill_valid`.
- R8: On a refill, `line_valid` and `done` each pulse exactly once, one clock after the last data beat.
- R9: On a write-back (`req_write` = 1), the address beat is followed by 8 data beats on consecutive ticks. In beat `j`, `wb_word_idx` = `bus_beat_idx` = `j` and `bus_wdata` equals `wb_data`. After the beats come `MEM_LAT` idle ticks, and `done` pulses one clock after the last of them. `fill_valid`, `cpu_restart` and `line_valid` stay low for the whole write-back.
- R10: A `req_valid` raised while `busy` is high is ignored. It causes no further address beat, no change of `bus_addr`, and no extra `done`.
- R11: While `rst_n` is low, `busy`, `done`, `fill_valid`, `cpu_restart` and `line_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write-back of a dirty line, 0 = refill |
| req_line_addr | input | ADDR_W | Line address |
| req_word_off | input | OFF_W | Requested word inside the line |
| req_crit_first | input | 1 | Refill with critical word first and early restart |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| wb_word_idx | output | OFF_W | Index of the dirty word wanted from the cache |
| wb_data | input | WORD_W | Dirty word supplied by the cache for `wb_word_idx` |
| fill_valid | output | 1 | Refill word available on `fill_idx`/`fill_data` |
| fill_idx | output | OFF_W | Index of the delivered refill word |
| fill_data | output | WORD_W | Delivered refill word |
| cpu_restart | output | 1 | One-clock pulse releasing the CPU |
| line_valid | output | 1 | One-clock pulse: whole line received |
| bus_tick | output | 1 | Bus clock enable |
| bus_addr_strobe | output | 1 | Address beat on the bus |
| bus_addr | output | ADDR_W | Line address on the bus |
| bus_we | output | 1 | Bus direction, 1 = write |
| bus_beat_strobe | output | 1 | Data beat on the bus |
| bus_beat_idx | output | OFF_W | Word index of the current data beat |
| bus_wdata | output | WORD_W | Write data of the current beat |
| bus_rdata | input | WORD_W | Read data from memory, sampled in a read beat |

## Verification
The bench builds the engine with its defaults: 32-bit words, 8 words per line, a 10-tick memory latency and a divide-by-4 bus enable. With 8 words, every starting offset from 0 to 7 can be driven, so every wrap point of the critical-word order is reached, including offset 7, which wraps straight after the first beat. With the short latency and divider, a full transfer takes about 75 clocks. That lets the bench run many refills and write-backs with random address, offset and mode, plus requests injected mid-transfer, and check every beat to the exact clock against the address beat.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        XS_IDLE  = 3'd0,
        XS_ADDR  = 3'd1,
        XS_RLAT  = 3'd2,
        XS_RDATA = 3'd3,
        XS_WDATA = 3'd4,
        XS_WLAT  = 3'd5
    } xfer_state_e;

endpackage

// File: rtl/xfer_bus_div.sv
module xfer_bus_div #(
    parameter int BUS_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (BUS_DIV > 1) ? $clog2(BUS_DIV) : 1;
    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(BUS_DIV - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == CNT_LAST);

    generate
        if (BUS_DIV > 1) begin : g_gap_chk
            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("bus enable high on two adjacent clocks");
        end
    endgenerate

endmodule

// File: rtl/xfer_word_order.sv
module xfer_word_order #(
    parameter int LINE_WORDS = 8,
    parameter int OFF_W      = 3
) (
    input  logic             crit_en,
    input  logic [OFF_W-1:0] base_off,
    input  logic [OFF_W-1:0] beat,
    output logic [OFF_W-1:0] word_idx
);
    localparam bit POW2 = ((LINE_WORDS & (LINE_WORDS - 1)) == 0);

    generate
        if (POW2) begin : g_pow2
            // wrap-around falls out of the truncated sum
            logic [OFF_W-1:0] wrap_sum;
            assign wrap_sum = base_off + beat;
            assign word_idx = crit_en ? wrap_sum : beat;
        end else begin : g_mod
            logic [OFF_W:0] raw_sum;
            logic [OFF_W:0] wrap_sum;
            assign raw_sum  = {1'b0, base_off} + {1'b0, beat};
            assign wrap_sum = (raw_sum >= (OFF_W+1)'(LINE_WORDS))
                            ? raw_sum - (OFF_W+1)'(LINE_WORDS) : raw_sum;
            assign word_idx = crit_en ? wrap_sum[OFF_W-1:0] : beat;
        end
    endgenerate

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int ADDR_W     = 27,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int MEM_LAT    = 10,
    parameter int OFF_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_crit,
    input  logic [OFF_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              busy,
    output logic              order_crit,
    output logic [OFF_W-1:0]  order_off,
    output logic [OFF_W-1:0]  order_beat,
    output logic              bus_addr_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_beat_strobe,
    output logic              fill_valid,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [WORD_W-1:0] fill_data,
    output logic              cpu_restart,
    output logic              line_valid,
    output logic              done
);
    localparam int LAT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
    localparam logic [LAT_W-1:0] LAT_LAST  = LAT_W'(MEM_LAT - 1);
    localparam logic [OFF_W-1:0] BEAT_LAST = OFF_W'(LINE_WORDS - 1);

    typedef struct packed {
        xfer_state_e        st;
        logic [ADDR_W-1:0]  addr;
        logic [OFF_W-1:0]   off;
        logic               crit;
        logic               wr;
        logic [OFF_W-1:0]   beat;
        logic [LAT_W-1:0]   lat;
        logic               fill_v;
        logic [OFF_W-1:0]   fill_i;
        logic [WORD_W-1:0]  fill_dat;
        logic               restart;
        logic               lvalid;
        logic               done;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.fill_v  = 1'b0;
        r_d.restart = 1'b0;
        r_d.lvalid  = 1'b0;
        r_d.done    = 1'b0;
        unique case (r_q.st)
            XS_IDLE: begin
                if (req_valid) begin
                    r_d.st   = XS_ADDR;
                    r_d.addr = req_addr;
                    r_d.off  = req_off;
                    r_d.crit = req_crit;
                    r_d.wr   = req_write;
                    r_d.beat = '0;
                    r_d.lat  = '0;
                end
            end
            XS_ADDR: begin
                if (tick) begin
                    r_d.st = r_q.wr ? XS_WDATA : XS_RLAT;
                end
            end
            XS_RLAT: begin
                if (tick) begin
                    if (r_q.lat == LAT_LAST) begin
                        r_d.lat = '0;
                        r_d.st  = XS_RDATA;
                    end else begin
                        r_d.lat = r_q.lat + LAT_W'(1);
                    end
                end
            end
            XS_RDATA: begin
                if (tick) begin
                    r_d.fill_v   = 1'b1;
                    r_d.fill_i   = word_idx;
                    r_d.fill_dat = bus_rdata;
                    if (r_q.crit && r_q.beat == '0) begin
                        r_d.restart = 1'b1;
                    end
                    if (r_q.beat == BEAT_LAST) begin
                        r_d.beat   = '0;
                        r_d.st     = XS_IDLE;
                        r_d.lvalid = 1'b1;
                        r_d.done   = 1'b1;
                        if (!r_q.crit) begin
                            r_d.restart = 1'b1;
                        end
                    end else begin
                        r_d.beat = r_q.beat + OFF_W'(1);
                    end
                end
            end
            XS_WDATA: begin
                if (tick) begin
                    if (r_q.beat == BEAT_LAST) begin
                        r_d.beat = '0;
                        r_d.lat  = '0;
                        r_d.st   = XS_WLAT;
                    end else begin
                        r_d.beat = r_q.beat + OFF_W'(1);
                    end
                end
            end
            XS_WLAT: begin
                if (tick) begin
                    if (r_q.lat == LAT_LAST) begin
                        r_d.lat  = '0;
                        r_d.st   = XS_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.lat = r_q.lat + LAT_W'(1);
                    end
                end
            end
            default: begin
                r_d.st = XS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= XS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy            = (r_q.st != XS_IDLE);
    assign order_crit      = r_q.crit & ~r_q.wr;
    assign order_off       = r_q.off;
    assign order_beat      = r_q.beat;
    assign bus_addr_strobe = (r_q.st == XS_ADDR) && tick;
    assign bus_addr        = r_q.addr;
    assign bus_we          = r_q.wr;
    assign bus_beat_strobe = ((r_q.st == XS_RDATA) || (r_q.st == XS_WDATA)) && tick;
    assign fill_valid      = r_q.fill_v;
    assign fill_idx        = r_q.fill_i;
    assign fill_data       = r_q.fill_dat;
    assign cpu_restart     = r_q.restart;
    assign line_valid      = r_q.lvalid;
    assign done            = r_q.done;

    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid))
        else $error("busy rose without a request");

    assert_done_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done pulsed while still busy");

    assert_restart_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart |-> fill_valid)
        else $error("restart without a delivered word");

    assert_lvalid_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (fill_valid && done))
        else $error("line declared valid before the last word");

    assert_no_fill_on_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !bus_we)
        else $error("refill word reported during a write-back");

    assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr))
        else $error("bus address changed during a transfer");

endmodule

// File: rtl/line_xfer_engine.sv
module line_xfer_engine #(
    parameter int ADDR_W     = 27,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int MEM_LAT    = 10,
    parameter int BUS_DIV    = 4,
    localparam int OFF_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_line_addr,
    input  logic [OFF_W-1:0]  req_word_off,
    input  logic              req_crit_first,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  wb_word_idx,
    input  logic [WORD_W-1:0] wb_data,
    output logic              fill_valid,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [WORD_W-1:0] fill_data,
    output logic              cpu_restart,
    output logic              line_valid,
    output logic              bus_tick,
    output logic              bus_addr_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_beat_strobe,
    output logic [OFF_W-1:0]  bus_beat_idx,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);
    logic             ord_crit;
    logic [OFF_W-1:0] ord_off;
    logic [OFF_W-1:0] ord_beat;
    logic [OFF_W-1:0] ord_idx;

    xfer_bus_div #(
        .BUS_DIV (BUS_DIV)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bus_tick)
    );

    xfer_word_order #(
        .LINE_WORDS (LINE_WORDS),
        .OFF_W      (OFF_W)
    ) i_order (
        .crit_en  (ord_crit),
        .base_off (ord_off),
        .beat     (ord_beat),
        .word_idx (ord_idx)
    );

    xfer_ctrl #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .MEM_LAT    (MEM_LAT),
        .OFF_W      (OFF_W)
    ) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (bus_tick),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_addr        (req_line_addr),
        .req_off         (req_word_off),
        .req_crit        (req_crit_first),
        .word_idx        (ord_idx),
        .bus_rdata       (bus_rdata),
        .busy            (busy),
        .order_crit      (ord_crit),
        .order_off       (ord_off),
        .order_beat      (ord_beat),
        .bus_addr_strobe (bus_addr_strobe),
        .bus_addr        (bus_addr),
        .bus_we          (bus_we),
        .bus_beat_strobe (bus_beat_strobe),
        .fill_valid      (fill_valid),
        .fill_idx        (fill_idx),
        .fill_data       (fill_data),
        .cpu_restart     (cpu_restart),
        .line_valid      (line_valid),
        .done            (done)
    );

    assign bus_beat_idx = ord_idx;
    assign wb_word_idx  = ord_idx;
    assign bus_wdata    = wb_data;

endmodule

// File: tb/test_line_xfer_engine.sv
module test_line_xfer_engine;
    localparam int AW  = 27;
    localparam int WW  = 32;
    localparam int NW  = 8;
    localparam int LAT = 10;
    localparam int DIV = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_write, req_crit_first;
    logic [AW-1:0] req_line_addr;
    logic [2:0]    req_word_off;
    logic          busy, done, fill_valid, cpu_restart, line_valid;
    logic [2:0]    wb_word_idx, fill_idx, bus_beat_idx;
    logic [WW-1:0] wb_data, fill_data, bus_wdata, bus_rdata;
    logic          bus_tick, bus_addr_strobe, bus_we, bus_beat_strobe;
    logic [AW-1:0] bus_addr;
    logic [AW-1:0] cur_addr;

    function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a, input logic [2:0] i);
        return (({5'd0, a} << 3) | {29'd0, i}) ^ 32'hC0DE_0000;
    endfunction

    function automatic int exp_idx(input bit wr, input bit cw, input int off, input int j);
        if (!wr && cw) return (off + j) % NW;
        return j;
    endfunction

    assign bus_rdata = mem_word(cur_addr, bus_beat_idx);
    assign wb_data   = ~mem_word(cur_addr, wb_word_idx);

    line_xfer_engine i_line_xfer_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line_addr(req_line_addr), .req_word_off(req_word_off),
        .req_crit_first(req_crit_first), .busy(busy), .done(done),
        .wb_word_idx(wb_word_idx), .wb_data(wb_data), .fill_valid(fill_valid),
        .fill_idx(fill_idx), .fill_data(fill_data), .cpu_restart(cpu_restart),
        .line_valid(line_valid), .bus_tick(bus_tick), .bus_addr_strobe(bus_addr_strobe),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_beat_strobe(bus_beat_strobe),
        .bus_beat_idx(bus_beat_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // monitor state
    int            n_addr, addr_cyc, addr_busy, n_beat, n_fill, n_rst, rst_cyc;
    int            n_lv, lv_cyc, n_done, done_cyc, done_busy;
    int            off_tick = 0, bad_gap = 0, last_tick = -1;
    logic [AW-1:0] addr_seen;
    int            beat_cyc [NW];
    int            beat_idx [NW];
    int            wbi      [NW];
    logic [WW-1:0] beat_wd  [NW];
    int            fill_cyc [NW];
    int            fill_i   [NW];
    logic [WW-1:0] fill_d   [NW];
    bit            mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (bus_tick) begin
                if (last_tick >= 0 && cyc - last_tick != DIV) bad_gap++;
                last_tick = cyc;
            end
            if ((bus_addr_strobe || bus_beat_strobe) && !bus_tick) off_tick++;
            if (bus_addr_strobe) begin
                n_addr++; addr_cyc = cyc; addr_seen = bus_addr; addr_busy = busy;
            end
            if (bus_beat_strobe) begin
                if (n_beat < NW) begin
                    beat_cyc[n_beat] = cyc; beat_idx[n_beat] = bus_beat_idx;
                    beat_wd[n_beat] = bus_wdata; wbi[n_beat] = wb_word_idx;
                end
                n_beat++;
            end
            if (fill_valid) begin
                if (n_fill < NW) begin
                    fill_cyc[n_fill] = cyc; fill_i[n_fill] = fill_idx; fill_d[n_fill] = fill_data;
                end
                n_fill++;
            end
            if (cpu_restart) begin n_rst++; rst_cyc = cyc; end
            if (line_valid)  begin n_lv++;  lv_cyc  = cyc; end
            if (done)        begin n_done++; done_cyc = cyc; done_busy = busy; end
        end
    end

    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input int off,
                           input bit cw, input bit poke);
        int k;
        int t;
        int base;
        int endc;
        @(posedge clk);
        #1;
        n_addr = 0; n_beat = 0; n_fill = 0; n_rst = 0; n_lv = 0; n_done = 0;
        addr_cyc = -1; rst_cyc = -1; lv_cyc = -1; done_cyc = -1; done_busy = 1; addr_busy = 0;
        cur_addr = a;
        @(negedge clk);
        k = cyc;
        req_valid = 1'b1; req_write = wr; req_line_addr = a;
        req_word_off = 3'(off); req_crit_first = cw;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_write = ~wr; req_line_addr = ~a; req_word_off = 3'(off + 3);
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);

        chk(n_addr == 1, "R3", "address beats", n_addr, 1);
        chk(addr_seen == a, "R3", "bus address", addr_seen, a);
        chk(addr_cyc - k >= 1 && addr_cyc - k <= DIV, "R3", "address beat delay", addr_cyc - k, 1);
        chk(addr_busy == 1, "R2", "busy during transfer", addr_busy, 1);
        chk(n_done == 1, "R8", "done pulses", n_done, 1);
        chk(done_busy == 0, "R2", "busy in done clock", done_busy, 0);
        chk(n_beat == NW, wr ? "R9" : "R4", "data beats", n_beat, NW);
        base = wr ? 1 : 1 + LAT;
        endc = addr_cyc + DIV * (NW + LAT) + 1;
        for (int j = 0; j < NW; j++) begin
            chk(beat_cyc[j] == addr_cyc + DIV * (base + j), wr ? "R9" : "R4",
                "beat clock", beat_cyc[j] - addr_cyc, DIV * (base + j));
            chk(beat_idx[j] == exp_idx(wr, cw, off, j), wr ? "R9" : (cw ? "R5" : "R6"),
                "beat word index", beat_idx[j], exp_idx(wr, cw, off, j));
        end
        if (!wr) begin
            chk(n_fill == NW, "R5", "fill pulses", n_fill, NW);
            for (int j = 0; j < NW; j++) begin
                chk(fill_cyc[j] == beat_cyc[j] + 1, "R5", "fill clock", fill_cyc[j] - beat_cyc[j], 1);
                chk(fill_i[j] == exp_idx(0, cw, off, j), cw ? "R5" : "R6", "fill index",
                    fill_i[j], exp_idx(0, cw, off, j));
                chk(fill_d[j] == mem_word(a, 3'(exp_idx(0, cw, off, j))), "R5", "fill data",
                    fill_d[j], mem_word(a, 3'(exp_idx(0, cw, off, j))));
            end
            chk(n_rst == 1, "R7", "restart pulses", n_rst, 1);
            chk(rst_cyc == (cw ? beat_cyc[0] + 1 : endc), "R7", "restart clock",
                rst_cyc - addr_cyc, (cw ? beat_cyc[0] + 1 : endc) - addr_cyc);
            chk(n_lv == 1, "R8", "line valid pulses", n_lv, 1);
            chk(lv_cyc == endc, "R8", "line valid clock", lv_cyc - addr_cyc, endc - addr_cyc);
            chk(done_cyc == endc, "R8", "done clock", done_cyc - addr_cyc, endc - addr_cyc);
        end else begin
            chk(n_fill == 0 && n_rst == 0 && n_lv == 0, "R9", "refill outputs on write-back",
                n_fill + n_rst + n_lv, 0);
            for (int j = 0; j < NW; j++) begin
                chk(wbi[j] == j, "R9", "dirty word index", wbi[j], j);
                chk(beat_wd[j] == ~mem_word(a, 3'(j)), "R9", "write data",
                    beat_wd[j], ~mem_word(a, 3'(j)));
            end
            chk(done_cyc == endc, "R9", "write-back done clock", done_cyc - addr_cyc, endc - addr_cyc);
        end
        if (poke) begin
            chk(n_addr == 1 && n_done == 1 && addr_seen == a, "R10", "ignored request effects",
                n_addr + n_done, 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_crit_first = 1'b0;
        req_line_addr = '0; req_word_off = '0; cur_addr = '0;
        repeat (5) @(negedge clk);
        chk(busy == 0 && done == 0, "R11", "busy/done in reset", busy + done, 0);
        chk(fill_valid == 0 && cpu_restart == 0 && line_valid == 0, "R11",
            "refill outputs in reset", fill_valid + cpu_restart + line_valid, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // directed corner cases
        run_txn(0, 27'h0123456, 5, 1, 0);
        run_txn(0, 27'h7FFFFFF, 7, 1, 0);
        run_txn(0, 27'h0000000, 0, 1, 0);
        run_txn(0, 27'h0ABCDEF, 3, 0, 0);
        run_txn(1, 27'h1234567, 6, 1, 0);
        run_txn(0, 27'h0F0F0F0, 2, 1, 1);
        run_txn(1, 27'h3C3C3C3, 0, 0, 1);

        // random mix
        for (int n = 0; n < 16; n++) begin
            run_txn(1'($urandom() % 2), AW'($urandom()), int'($urandom() % NW),
                    1'($urandom() % 2), ($urandom() % 4) == 0);
        end

        chk(bad_gap == 0, "R1", "bus enable spacing errors", bad_gap, 0);
        chk(off_tick == 0, "R1", "strobes off the bus enable", off_tick, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule